// File: doc/BRIEF.md
# Synchronous Receive Input Conditioner

This block sits in front of the shift logic of a synchronous serial receiver. It takes three external pins: serial data, a receive clock supplied by the far end, and a carrier-detect level. It brings them into the system clock domain and finds the receive-clock edge selected by software. For each such edge it issues a one-cycle bit strobe together with the conditioned data bit. An 8-bit control register makes data inversion, the choice of rising or falling clock edge, and carrier-detect gating each programmable, along with the active level of carrier detect. A master enable bit in the same register switches all of these options on or off together.

Two mode inputs, driven from elsewhere in the receiver, change the data paths. Auto-echo drives three echo outputs straight from the raw pins, with no conditioning applied, while the receiver keeps working. Loop-back feeds the internal transmit clock and data into the receiver in place of the pins, and ignores every conditioning option.

Edge detection is a three-state machine. `SETTLE` waits out the synchronizer depth after reset or after a change of source or edge sense, then takes the current clock level without issuing a strobe. Its transitions are SETTLE→LOW when the normalized clock is low and SETTLE→HIGH when it is high. `LOW` waits for the active edge; the transition LOW→HIGH is the qualified edge and issues the strobe if the gate is open. `HIGH` waits for the clock to return, and HIGH→LOW rearms the machine. From any state, a mode change forces the transition →SETTLE.

Top module: `srx_input_cond`

## Requirements
- R1: The control register resets to 0x03. A write with `cfg_we` high loads all eight bits of `cfg_wdata`, and `cfg_q` shows them from the next cycle. Field positions: bit 7 is the master enable, bit 6 inverts data, bit 5 selects the edge (0 rising, 1 falling), bit 4 enables gating, and bit 3 sets the carrier-detect active level (0 low, 1 high). Bits 2:0 are stored but have no effect.
- R2: Each qualified active receive-clock edge produces `bit_stb` high for exactly one cycle. If the clock pin changes between system edges k-1 and k, the strobe is high in the cycle after edge k+2. `bit_data` then shows the data pin value captured at edge k, conditioned as below.
- R3: With bit 7 set, bit 5 = 0 makes the rising edge of the receive clock active, and bit 5 = 1 makes the falling edge active.
- R4: With bit 7 set and bit 6 = 1, `bit_data` is the inverse of the data pin.
- R5: With bits 7 and 4 set, an active edge produces a strobe only if the synchronized carrier detect at that edge equals bit 3. Otherwise the edge is dropped.
- R6: With bit 7 clear, bits 6 to 3 have no effect: rising edges are active, data is not inverted, and there is no gating.
- R7: With `lb_en` high, the strobe and data come from `tx_clk_int` (rising edge) and `tx_data_int`. The pins and control bits 6 to 3 have no effect.
- R8: With `echo_en` high, `echo_data_o`, `echo_clk_o` and `echo_rts_o` follow the raw data, clock and carrier-detect pins combinationally, whatever the control bits are. With `echo_en` low, all three are 0.
- R9: After a change of `lb_en`, or of the effective edge selection, no strobe is issued for the next SYNC_STAGES+2 cycles. The clock level at the end of that window is taken as the reference without producing a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write value |
| cfg_q | output | 8 | Control register contents |
| lb_en | input | 1 | Loop-back mode select |
| echo_en | input | 1 | Auto-echo mode select |
| rx_data_pin | input | 1 | Raw serial data pin |
| rx_clk_pin | input | 1 | Raw external receive clock |
| dcd_pin | input | 1 | Raw carrier-detect pin |
| tx_clk_int | input | 1 | Internal transmit clock level (loop-back source) |
| tx_data_int | input | 1 | Internal transmit data (loop-back source) |
| bit_stb | output | 1 | One-cycle received-bit strobe |
| bit_data | output | 1 | Conditioned data bit, valid with the strobe |
| echo_data_o | output | 1 | Echoed raw data |
| echo_clk_o | output | 1 | Echoed raw receive clock |
| echo_rts_o | output | 1 | Echoed raw carrier detect |

## Verification
A slow receive clock carrying pseudo-random data is applied under six settings: the master enable off with the other fields set, rising edge, inverted data, falling edge, gating with carrier detect inactive and then active, and loop-back with the pins toggling. The strobe counts show whether the right edge is chosen and whether gated edges are dropped. The per-cycle data comparison shows whether inversion was applied on the right path. A clock toggling every cycle while the edge sense is rewritten shows whether the settle window suppresses spurious strobes. Echo outputs are compared against the raw pins while the control register holds values that would condition the receive path.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int          CFG_W   = 8;
    localparam logic [7:0]  CFG_RST = 8'h03;
    localparam int          B_SYNC  = 7;
    localparam int          B_INV   = 6;
    localparam int          B_FALL  = 5;
    localparam int          B_GATE  = 4;
    localparam int          B_GPOL  = 3;

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_LOW    = 2'd1,
        ST_HIGH   = 2'd2
    } edge_st_e;

    typedef struct packed {
        logic inv;
        logic fall;
        logic gate_en;
        logic gate_pol;
    } cond_t;
endpackage

// File: rtl/srx_ctrl_reg.sv
module srx_ctrl_reg
    import srx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             lb_en,
    output logic [CFG_W-1:0] cfg_q,
    output cond_t            eff
);
    logic act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else if (we) cfg_q <= wdata;
    end

    // Conditioning applies only when enabled and not in loop-back.
    assign act          = cfg_q[B_SYNC] & ~lb_en;
    assign eff.inv      = act & cfg_q[B_INV];
    assign eff.fall     = act & cfg_q[B_FALL];
    assign eff.gate_en  = act & cfg_q[B_GATE];
    assign eff.gate_pol = cfg_q[B_GPOL];

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cfg_q == $past(wdata)); // R1
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q)); // R1
endmodule

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/srx_edge_fsm.sv
module srx_edge_fsm
    import srx_pkg::*;
#(
    parameter int SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic gate_open,
    input  logic mode_chg,
    input  logic din,
    output logic stb,
    output logic dout
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    edge_st_e   state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic       edge_hit;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (mode_chg) begin
            state_d = ST_SETTLE;
            cnt_d   = CNT_W'(SETTLE_CYC);
        end else begin
            unique case (state_q)
                ST_SETTLE: begin
                    if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
                    else             state_d = lvl ? ST_HIGH : ST_LOW;
                end
                ST_LOW:  if (lvl)  state_d = ST_HIGH;
                ST_HIGH: if (!lvl) state_d = ST_LOW;
                default: state_d = ST_SETTLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
            cnt_q   <= CNT_W'(SETTLE_CYC);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign edge_hit = (state_q == ST_LOW) && lvl && !mode_chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb  <= 1'b0;
            dout <= 1'b0;
        end else begin
            stb  <= edge_hit && gate_open;
            dout <= din;
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb); // R2
    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |=> !stb); // R9
endmodule

// File: rtl/srx_input_cond.sv
module srx_input_cond
    import srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q,
    input  logic             lb_en,
    input  logic             echo_en,
    input  logic             rx_data_pin,
    input  logic             rx_clk_pin,
    input  logic             dcd_pin,
    input  logic             tx_clk_int,
    input  logic             tx_data_int,
    output logic             bit_stb,
    output logic             bit_data,
    output logic             echo_data_o,
    output logic             echo_clk_o,
    output logic             echo_rts_o
);
    localparam int SIG_W = 3;

    cond_t            eff;
    logic [SIG_W-1:0] src, syn;
    logic             s_clk, s_dat, s_dcd;
    logic [1:0]       mode_now, mode_prev;
    logic             mode_chg, lvl, gate_open, din;

    srx_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .lb_en (lb_en),
        .cfg_q (cfg_q),
        .eff   (eff)
    );

    // Source selection ahead of the synchronizers keeps one latency for both paths.
    assign src = lb_en ? {tx_clk_int, tx_data_int, 1'b0}
                       : {rx_clk_pin, rx_data_pin, dcd_pin};

    srx_sync #(.WIDTH(SIG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src),
        .q     (syn)
    );

    assign {s_clk, s_dat, s_dcd} = syn;

    assign mode_now = {lb_en, eff.fall};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_prev <= 2'b00;
        else        mode_prev <= mode_now;
    end

    assign mode_chg  = (mode_now != mode_prev);
    assign lvl       = s_clk ^ eff.fall;
    assign gate_open = !eff.gate_en || (s_dcd == eff.gate_pol);
    assign din       = s_dat ^ eff.inv;

    srx_edge_fsm #(.SETTLE_CYC(SYNC_STAGES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl),
        .gate_open (gate_open),
        .mode_chg  (mode_chg),
        .din       (din),
        .stb       (bit_stb),
        .dout      (bit_data)
    );

    assign echo_data_o = echo_en & rx_data_pin;
    assign echo_clk_o  = echo_en & rx_clk_pin;
    assign echo_rts_o  = echo_en & dcd_pin;

    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (eff.gate_en && (s_dcd != eff.gate_pol)) |=> !bit_stb); // R5
    AST_MODE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !bit_stb); // R9
    AST_LB_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
        lb_en |=> bit_data == $past(s_dat)); // R7
endmodule

// File: tb/srx_input_cond_tb.sv
module srx_input_cond_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_q;
    logic       lb_en = 1'b0, echo_en = 1'b0;
    logic       rx_data_pin = 1'b0, rx_clk_pin = 1'b0, dcd_pin = 1'b1;
    logic       tx_clk_int = 1'b0, tx_data_int = 1'b0;
    logic       bit_stb, bit_data, echo_data_o, echo_clk_o, echo_rts_o;

    int nvec = 0, nerr = 0, seen = 0;
    bit done = 1'b0;
    string cur_req = "R2";
    logic [15:0] lfsr = 16'hACE1;

    // Reference model state
    bit [7:0] cfg_m = 8'h03;
    int prev_m = 0, blank = 2, lvl_m = -1;
    bit m1c, m1d, m1g, m2c, m2d, m2g;
    bit exp_stb = 0, exp_dat = 0;

    always #5 clk = ~clk;

    srx_input_cond dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .lb_en(lb_en), .echo_en(echo_en),
        .rx_data_pin(rx_data_pin), .rx_clk_pin(rx_clk_pin), .dcd_pin(dcd_pin),
        .tx_clk_int(tx_clk_int), .tx_data_int(tx_data_int),
        .bit_stb(bit_stb), .bit_data(bit_data), .echo_data_o(echo_data_o),
        .echo_clk_o(echo_clk_o), .echo_rts_o(echo_rts_o)
    );

    function automatic bit rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    function automatic void check(string req, string what, int act, int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endfunction

    // Advance the model by one system clock edge using the inputs now applied.
    function automatic void model_adv();
        bit act  = cfg_m[7] && !lb_en;
        bit fall = act && cfg_m[5];
        bit inv  = act && cfg_m[6];
        bit gen  = act && cfg_m[4];
        bit n    = m2c ^ fall;
        bit gate = !gen || (m2g == cfg_m[3]);
        int mode = (lb_en ? 2 : 0) + (fall ? 1 : 0);
        exp_dat = m2d ^ inv;
        if (mode != prev_m) begin
            blank = 2; exp_stb = 0; lvl_m = -1;
        end else if (blank > 0) begin
            blank--; exp_stb = 0;
        end else if (lvl_m < 0) begin
            lvl_m = n; exp_stb = 0;
        end else begin
            exp_stb = (lvl_m == 0) && n && gate;
            lvl_m = n;
        end
        prev_m = mode;
        m2c = m1c; m2d = m1d; m2g = m1g;
        if (lb_en) begin m1c = tx_clk_int; m1d = tx_data_int; m1g = 0; end
        else       begin m1c = rx_clk_pin; m1d = rx_data_pin; m1g = dcd_pin; end
        if (cfg_we) cfg_m = cfg_wdata;
    endfunction

    task automatic cyc();
        #1;
        check("R8", "echo_data", echo_data_o, echo_en ? rx_data_pin : 0);
        check("R8", "echo_clk",  echo_clk_o,  echo_en ? rx_clk_pin  : 0);
        check("R8", "echo_rts",  echo_rts_o,  echo_en ? dcd_pin     : 0);
        model_adv();
        @(negedge clk);
        check(cur_req, "bit_stb",  bit_stb,  exp_stb);
        check(cur_req, "bit_data", bit_data, exp_dat);
        if (bit_stb) seen++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_cfg(logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        cyc();
        cfg_we = 1'b0;
        check("R1", "cfg_q readback", cfg_q, v);
    endtask

    // Toggle the selected clock source; data changes on each low phase.
    task automatic run_clk(int edges, int hold, bit use_tx);
        for (int e = 0; e < edges; e++) begin
            if (use_tx) begin
                tx_clk_int = ~tx_clk_int;
                if (!tx_clk_int) tx_data_int = rnd();
                rx_clk_pin = rnd(); rx_data_pin = rnd(); dcd_pin = rnd();
            end else begin
                rx_clk_pin = ~rx_clk_pin;
                if (!rx_clk_pin) rx_data_pin = rnd();
            end
            idle(hold);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset cfg_q", cfg_q, 8'h03);
        check("R2", "reset bit_stb", bit_stb, 0);
        rst_n = 1'b1;
        idle(4);

        // R6: enable bit clear, other fields set: plain rising edge
        cur_req = "R6";
        wr_cfg(8'h7B);
        idle(4); seen = 0;
        run_clk(8, 3, 0); idle(5);
        check("R6", "strobe count", seen, 4);

        // R2 / R3: enabled, rising edge
        cur_req = "R3";
        wr_cfg(8'h80);
        idle(4); seen = 0;
        run_clk(8, 3, 0); idle(5);
        check("R3", "rising strobe count", seen, 4);

        // R4: inverted data
        cur_req = "R4";
        wr_cfg(8'hC0);
        idle(4);
        run_clk(12, 2, 0); idle(5);

        // R3: falling edge
        cur_req = "R3";
        wr_cfg(8'hA0);
        idle(6); seen = 0;
        run_clk(8, 3, 0); idle(5);
        check("R3", "falling strobe count", seen, 4);

        // R9: rewrite edge sense while clock toggles every cycle
        cur_req = "R9";
        for (int i = 0; i < 12; i++) begin
            rx_clk_pin = ~rx_clk_pin;
            rx_data_pin = rnd();
            cfg_we = (i == 3); cfg_wdata = 8'h80;
            cyc();
            if (i == 3) seen = 0;
            cfg_we = 1'b0;
        end
        idle(6);

        // R5: gating active low, carrier inactive then active
        cur_req = "R5";
        rx_clk_pin = 1'b0; idle(6);
        wr_cfg(8'h90);
        dcd_pin = 1'b1; idle(4); seen = 0;
        run_clk(8, 3, 0); idle(5);
        check("R5", "gated strobe count (inactive)", seen, 0);
        dcd_pin = 1'b0; idle(4); seen = 0;
        run_clk(8, 3, 0); idle(5);
        check("R5", "gated strobe count (active)", seen, 4);
        wr_cfg(8'h98);
        idle(3); seen = 0;
        run_clk(8, 3, 0); idle(5);
        check("R5", "gated strobe count (active-high, dcd low)", seen, 0);
        dcd_pin = 1'b1; idle(3);
        run_clk(16, 1, 0); idle(5);

        // R7: loop-back with every conditioning bit set and pins scrambled
        cur_req = "R7";
        wr_cfg(8'hFB);
        lb_en = 1'b1; idle(6); seen = 0;
        run_clk(8, 3, 1); idle(5);
        check("R7", "loop-back strobe count", seen, 4);
        lb_en = 1'b0; idle(6);

        // R8: echo follows raw pins regardless of control bits
        cur_req = "R8";
        echo_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            rx_data_pin = i[0]; rx_clk_pin = i[1]; dcd_pin = i[2];
            cyc();
        end
        echo_en = 1'b0;
        rx_data_pin = 1'b1; rx_clk_pin = 1'b1; dcd_pin = 1'b1;
        idle(3);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule